// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block connects a small 8-bit controller core to memory outside the chip. Memory is reached over a shared 8-bit port and a separate 8-bit high port. The shared port first carries the low address byte and then the data byte. An address strobe tells external logic when to capture that low byte. The high port carries the upper address byte. For 8-bit-address data accesses, it carries the value of the high port's own output register instead.

Time is divided into machine cycles of six states, two clocks each, so twelve clocks per cycle. Each machine cycle is one bus slot.
- **Clocks 0–3** form the address phase.
- **Clocks 4–11** form the data phase.

The core offers at most one request per slot through a valid/ready handshake. Ready is high only on the last clock of a cycle. A request is taken when valid and ready are both high. Request fields must stay stable while valid waits for ready. The access then runs in the next machine cycle. On the last clock of that cycle, a one-clock done pulse is raised, with read data beside it. The response has no back-pressure: the core must take it on that clock.

The block also holds two registers written through a simple register-write port:
- a bit that disables the address strobe;
- the high-port output register.

The strobe-disable bit is set aside during data moves, code table reads, low-power modes, emulation mode and external execution. A reset input must stay high for two full machine cycles before it takes effect.

Top module: `ebus_ctrl`

## Requirements
- R1: In clocks 0–3 of every machine cycle, the shared port is driven. It carries the low address byte during an access and 0xFF in an idle cycle. The address strobe `ale` is high in exactly those clocks and low in clocks 4–11, unless suppressed (R7).
- R2: During an access of kind 0 (fetch), 1 (code table read), 2 (16-bit data read) or 4 (16-bit data write), `hi_out` carries address bits 15:8 for the whole machine cycle.
- R3: During an access of kind 3 (8-bit data read) or 5 (8-bit data write), and in idle cycles, `hi_out` carries the high-port register. That register is written by a register write to address 0xA0 and resets to 0xFF.
- R4: During a read (kinds 2, 3), `rd_n` is low in clocks 4–10 and the shared port is released (`ad_oe` low) in clocks 4–11. For all non-write kinds, `ad_in` is captured on the clock edge that ends clock 10 and presented on `rsp_data`. Fetch and code reads raise no strobe.
- R5: During a write (kinds 4, 5), `wr_n` is low in clocks 4–10. The write data is driven on the shared port through clocks 4–11, so it stays valid after `wr_n` rises. `rd_n` and `wr_n` are never low together.
- R6: `req_ready` is high only on clock 11 of each machine cycle. `rsp_valid` pulses for one clock on clock 11 of every accepted access, and never for an idle cycle.
- R7: Bit 0 of the register at address 0x8E disables the strobe. When the bit is set at the start of a cycle with no override, `ale` stays high and `ale_weak` is high for that whole cycle. Otherwise `ale_weak` is low.
- R8: The disable bit has no effect on a cycle whose accepted request is of kind 1 to 5, or while `idle_mode`, `pdown_mode` or `emu_mode` is high at the cycle's start.
- R9: While `ext_exec` is high, setting the disable bit has no effect on `ale`.
- R10: `rst` high for 24 consecutive clocks resets the block. The disable bit clears, the high-port register returns to 0xFF, strobes go high, `ready` and `ale` go low. A shorter pulse changes nothing. `por_n` low clears the same state at power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-up clear, active low |
| rst | input | 1 | Filtered reset request, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request slot open (clock 11) |
| req_kind | input | 3 | 0 fetch, 1 code read, 2 rd16, 3 rd8, 4 wr16, 5 wr8 |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Access done pulse |
| rsp_data | output | 8 | Captured read data |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| idle_mode | input | 1 | Core in idle mode |
| pdown_mode | input | 1 | Core in power-down mode |
| emu_mode | input | 1 | Core in emulation mode |
| ext_exec | input | 1 | Core executing from external code memory |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port input value |
| hi_out | output | 8 | High port output value |
| ale | output | 1 | Address strobe |
| ale_weak | output | 1 | Strobe held by weak pull-up only |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default parameters: two clocks per state and a reset filter of two machine cycles. This gives a 12-clock slot and a 24-clock reset threshold, so every phase boundary can be checked clock by clock. It also means a 10-clock reset pulse can be shown to do nothing while a 30-clock pulse resets. With these values, every request kind, each override source and the register-driven high port are all reached within a few hundred slots.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_CODE  = 3'd1,
    K_RD16  = 3'd2,
    K_RD8   = 3'd3,
    K_WR16  = 3'd4,
    K_WR8   = 3'd5
  } kind_e;

  function automatic logic kind_wide(kind_e k);
    return (k == K_FETCH) || (k == K_CODE) || (k == K_RD16) || (k == K_WR16);
  endfunction

  function automatic logic kind_dread(kind_e k);
    return (k == K_RD16) || (k == K_RD8);
  endfunction

  function automatic logic kind_write(kind_e k);
    return (k == K_WR16) || (k == K_WR8);
  endfunction

  function automatic logic kind_override(kind_e k);
    return (k == K_CODE) || kind_dread(k) || kind_write(k);
  endfunction
endpackage

// File: rtl/ebus_rst_filt.sv
module ebus_rst_filt #(
  parameter int HOLD_CLKS = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst,
  output logic rst_int
);
  localparam int CW = $clog2(HOLD_CLKS + 1);
  localparam logic [CW-1:0] CMAX = CW'(HOLD_CLKS);
  localparam logic [CW-1:0] CFIRE = CW'(HOLD_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt     <= '0;
      rst_int <= 1'b1;
    end else begin
      if (!rst)             cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
      rst_int <= rst && (cnt >= CFIRE);
    end
  end
endmodule

// File: rtl/ebus_regs.sv
module ebus_regs #(
  parameter logic [7:0] ALE_REG_ADDR = 8'h8E,
  parameter logic [7:0] HI_REG_ADDR  = 8'hA0
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_int,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       cyc_end,
  input  logic       nxt_override,
  output logic [7:0] hi_reg,
  output logic       sup_q
);
  logic dis_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dis_q  <= 1'b0;
      hi_reg <= 8'hFF;
      sup_q  <= 1'b0;
    end else if (rst_int) begin
      dis_q  <= 1'b0;
      hi_reg <= 8'hFF;
      sup_q  <= 1'b0;
    end else begin
      if (sfr_we && sfr_addr == ALE_REG_ADDR) dis_q <= sfr_wdata[0];
      if (sfr_we && sfr_addr == HI_REG_ADDR)  hi_reg <= sfr_wdata;
      if (cyc_end) sup_q <= dis_q && !nxt_override;
    end
  end

  AST_DIS_CLEARED: assert property (@(posedge clk) disable iff (!por_n)
    ($past(rst_int) && !rst_int) |-> (!dis_q && hi_reg == 8'hFF)); // R10
  AST_SUP_OVERRIDE: assert property (@(posedge clk) disable iff (!por_n || rst_int)
    (cyc_end && nxt_override) |=> !sup_q); // R8
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int CLKS_PER_STATE = 2,
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_int,
  input  logic          req_valid,
  input  kind_e         req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          cyc_end,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic [DW-1:0] hi_reg,
  input  logic          sup_q,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] hi_out,
  output logic          ale,
  output logic          ale_weak,
  output logic          rd_n,
  output logic          wr_n
);
  localparam int CYC = 6 * CLKS_PER_STATE;
  localparam int PW  = $clog2(CYC);
  localparam logic [PW-1:0] PH_LAST = PW'(CYC - 1);
  localparam logic [PW-1:0] PH_SMP  = PW'(CYC - 2);
  localparam logic [PW-1:0] PH_DATA = PW'(2 * CLKS_PER_STATE);

  logic [PW-1:0] ph;
  logic          cur_v;
  kind_e         cur_k;
  logic [AW-1:0] cur_a;
  logic [DW-1:0] cur_d;
  logic [DW-1:0] rdat;
  logic          addr_ph;
  logic          strb_win;

  assign cyc_end   = (ph == PH_LAST) && !rst_int;
  assign req_ready = cyc_end;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ph    <= PH_LAST;
      cur_v <= 1'b0;
      cur_k <= K_FETCH;
      cur_a <= '0;
      cur_d <= '0;
      rdat  <= '0;
    end else if (rst_int) begin
      ph    <= PH_LAST;
      cur_v <= 1'b0;
    end else begin
      ph <= cyc_end ? '0 : ph + 1'b1;
      if (cyc_end) begin
        cur_v <= req_valid;
        if (req_valid) begin
          cur_k <= req_kind;
          cur_a <= req_addr;
          cur_d <= req_wdata;
        end
      end
      if (cur_v && ph == PH_SMP && !kind_write(cur_k)) rdat <= ad_in;
    end
  end

  assign addr_ph  = ph < PH_DATA;
  assign strb_win = cur_v && !addr_ph && (ph != PH_LAST);

  always_comb begin
    ad_oe    = addr_ph || (cur_v && kind_write(cur_k));
    ad_out   = addr_ph ? (cur_v ? cur_a[DW-1:0] : {DW{1'b1}}) : cur_d;
    hi_out   = (cur_v && kind_wide(cur_k)) ? cur_a[AW-1 -: DW] : hi_reg;
    ale      = sup_q ? 1'b1 : (addr_ph && !rst_int);
    ale_weak = sup_q;
    rd_n     = !(strb_win && kind_dread(cur_k));
    wr_n     = !(strb_win && kind_write(cur_k));
  end

  assign rsp_valid = cur_v && cyc_end;
  assign rsp_data  = rdat;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!por_n || rst_int)
    !(!rd_n && !wr_n)); // R5
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!por_n || rst_int)
    !rd_n |-> !ad_oe); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!por_n || rst_int)
    $rose(wr_n) |-> ad_oe); // R5
  AST_ADDR_NO_STROBE: assert property (@(posedge clk) disable iff (!por_n || rst_int)
    req_ready |=> (rd_n && wr_n && ad_oe)); // R1
  AST_RSP_ONE: assert property (@(posedge clk) disable iff (!por_n || rst_int)
    rsp_valid |=> !rsp_valid); // R6
endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
#(
  parameter int CLKS_PER_STATE = 2,
  parameter int RST_MCYC = 2,
  parameter logic [7:0] ALE_REG_ADDR = 8'h8E,
  parameter logic [7:0] HI_REG_ADDR  = 8'hA0
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_kind,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  input  logic        sfr_we,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  input  logic        idle_mode,
  input  logic        pdown_mode,
  input  logic        emu_mode,
  input  logic        ext_exec,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic [7:0]  hi_out,
  output logic        ale,
  output logic        ale_weak,
  output logic        rd_n,
  output logic        wr_n
);
  localparam int HOLD_CLKS = RST_MCYC * 6 * CLKS_PER_STATE;

  logic       rst_int;
  logic       cyc_end;
  logic       sup_q;
  logic       nxt_override;
  logic [7:0] hi_reg;
  kind_e      kind;

  assign kind = kind_e'(req_kind);
  assign nxt_override = ext_exec || idle_mode || pdown_mode || emu_mode ||
                        (req_valid && kind_override(kind));

  ebus_rst_filt #(.HOLD_CLKS(HOLD_CLKS)) u_filt (
    .clk(clk), .por_n(por_n), .rst(rst), .rst_int(rst_int)
  );

  ebus_regs #(.ALE_REG_ADDR(ALE_REG_ADDR), .HI_REG_ADDR(HI_REG_ADDR)) u_regs (
    .clk(clk), .por_n(por_n), .rst_int(rst_int),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .cyc_end(cyc_end), .nxt_override(nxt_override),
    .hi_reg(hi_reg), .sup_q(sup_q)
  );

  ebus_seq #(.CLKS_PER_STATE(CLKS_PER_STATE), .AW(16), .DW(8)) u_seq (
    .clk(clk), .por_n(por_n), .rst_int(rst_int),
    .req_valid(req_valid), .req_kind(kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .cyc_end(cyc_end),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .hi_reg(hi_reg), .sup_q(sup_q),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_out(hi_out),
    .ale(ale), .ale_weak(ale_weak), .rd_n(rd_n), .wr_n(wr_n)
  );

  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    rst_int |-> (!req_ready && rd_n && wr_n)); // R10
endmodule

// File: tb/sim_ebus_ctrl.sv
module sim_ebus_ctrl;
  logic        clk = 1'b0;
  logic        por_n, rst, req_valid, sfr_we;
  logic        idle_mode, pdown_mode, emu_mode, ext_exec;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, sfr_addr, sfr_wdata, ad_in;
  logic        req_ready, rsp_valid, ad_oe, ale, ale_weak, rd_n, wr_n;
  logic [7:0]  rsp_data, ad_out, hi_out;

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  bit b_dis = 0;
  logic [7:0] b_hi = 8'hFF;

  always #4 clk = ~clk;

  ebus_ctrl u0 (.*);

  function automatic bit f_wide(logic [2:0] k);  return k == 0 || k == 1 || k == 2 || k == 4; endfunction
  function automatic bit f_dread(logic [2:0] k); return k == 2 || k == 3; endfunction
  function automatic bit f_write(logic [2:0] k); return k == 4 || k == 5; endfunction
  function automatic bit f_ovr(logic [2:0] k);   return k >= 1 && k <= 5; endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic sync_ready();
    while (req_ready !== 1'b1) @(negedge clk);
  endtask

  // Entered at a negedge with req_ready high; returns at the next such negedge.
  task automatic access(bit v, logic [2:0] k, logic [15:0] a, logic [7:0] wd,
                        logic [7:0] din, string atag);
    bit sup;
    bit ovr = ext_exec || idle_mode || pdown_mode || emu_mode || (v && f_ovr(k));
    sup = b_dis && !ovr;
    req_valid = v; req_kind = k; req_addr = a; req_wdata = wd; ad_in = ~din;
    for (int p = 0; p < 12; p++) begin
      @(negedge clk);
      if (p == 0) req_valid = 1'b0;
      ad_in = (p == 10) ? din : ~din;
      chk(ale === (sup ? 1'b1 : (p < 4)), atag, 16'(ale), 16'(sup ? 1'b1 : (p < 4)));
      chk(ale_weak === sup, atag, 16'(ale_weak), 16'(sup));
      chk(ad_oe === (p < 4 || (v && f_write(k))), (p < 4) ? "R1" : "R4", 16'(ad_oe),
          16'(p < 4 || (v && f_write(k))));
      if (p < 4) chk(ad_out === (v ? a[7:0] : 8'hFF), "R1", 16'(ad_out), 16'(v ? a[7:0] : 8'hFF));
      else if (v && f_write(k)) chk(ad_out === wd, "R5", 16'(ad_out), 16'(wd));
      chk(hi_out === ((v && f_wide(k)) ? a[15:8] : b_hi), (v && f_wide(k)) ? "R2" : "R3",
          16'(hi_out), 16'((v && f_wide(k)) ? a[15:8] : b_hi));
      chk(rd_n === !(v && f_dread(k) && p >= 4 && p <= 10), "R4", 16'(rd_n),
          16'(!(v && f_dread(k) && p >= 4 && p <= 10)));
      chk(wr_n === !(v && f_write(k) && p >= 4 && p <= 10), "R5", 16'(wr_n),
          16'(!(v && f_write(k) && p >= 4 && p <= 10)));
      chk(req_ready === (p == 11), "R6", 16'(req_ready), 16'(p == 11));
      chk(rsp_valid === (v && p == 11), "R6", 16'(rsp_valid), 16'(v && p == 11));
      if (p == 11 && v && !f_write(k)) chk(rsp_data === din, "R4", 16'(rsp_data), 16'(din));
    end
  endtask

  // One unchecked idle slot with a register write on its first clock.
  task automatic reg_write(logic [7:0] ad, logic [7:0] d);
    req_valid = 1'b0;
    sfr_we = 1'b1; sfr_addr = ad; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
    repeat (11) @(negedge clk);
    if (ad == 8'h8E) b_dis = d[0];
    if (ad == 8'hA0) b_hi = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    por_n = 0; rst = 0; req_valid = 0; sfr_we = 0; req_kind = 0; req_addr = 0;
    req_wdata = 0; sfr_addr = 0; sfr_wdata = 0; ad_in = 0;
    idle_mode = 0; pdown_mode = 0; emu_mode = 0; ext_exec = 0;
    repeat (3) @(negedge clk);
    chk(rd_n === 1'b1 && wr_n === 1'b1, "R10", 16'({rd_n, wr_n}), 16'h3);
    chk(hi_out === 8'hFF, "R10", 16'(hi_out), 16'hFF);
    chk(req_ready === 1'b0, "R10", 16'(req_ready), 16'h0);
    por_n = 1;
    @(negedge clk);
    sync_ready();

    access(0, 3'd0, 16'h0, 8'h0, 8'h0, "R1");
    access(1, 3'd0, 16'h12C4, 8'h00, 8'h3C, "R2");
    access(1, 3'd2, 16'hBEEF, 8'h00, 8'hA5, "R4");
    access(1, 3'd3, 16'h0077, 8'h00, 8'h00, "R3");
    reg_write(8'hA0, 8'h5A);
    access(1, 3'd5, 16'h9933, 8'hC3, 8'h00, "R3");
    access(0, 3'd0, 16'h0, 8'h0, 8'h0, "R3");
    access(1, 3'd4, 16'h4321, 8'hFF, 8'h00, "R5");
    access(1, 3'd1, 16'hF00D, 8'h00, 8'hFF, "R2");
    reg_write(8'h8E, 8'h01);
    access(1, 3'd0, 16'h1111, 8'h00, 8'h81, "R7");
    access(0, 3'd0, 16'h0, 8'h0, 8'h0, "R7");
    access(1, 3'd2, 16'h2222, 8'h00, 8'h18, "R8");
    access(1, 3'd1, 16'h3333, 8'h00, 8'h42, "R8");
    access(1, 3'd5, 16'h4444, 8'h99, 8'h00, "R8");
    idle_mode = 1;  access(1, 3'd0, 16'h5555, 8'h00, 8'h11, "R8"); idle_mode = 0;
    pdown_mode = 1; access(0, 3'd0, 16'h0, 8'h00, 8'h00, "R8"); pdown_mode = 0;
    emu_mode = 1;   access(1, 3'd0, 16'h6666, 8'h00, 8'h22, "R8"); emu_mode = 0;
    ext_exec = 1;   access(1, 3'd0, 16'h7777, 8'h00, 8'h33, "R9");
    access(0, 3'd0, 16'h0, 8'h00, 8'h00, "R9"); ext_exec = 0;

    // Short reset pulse: no effect.
    rst = 1; repeat (10) @(negedge clk); rst = 0; repeat (2) @(negedge clk);
    access(1, 3'd0, 16'h8888, 8'h00, 8'h44, "R10");
    // Long reset pulse.
    rst = 1; repeat (30) @(negedge clk);
    chk(req_ready === 1'b0, "R10", 16'(req_ready), 16'h0);
    chk(ale === 1'b0 && ale_weak === 1'b0, "R10", 16'({ale, ale_weak}), 16'h0);
    chk(hi_out === 8'hFF, "R10", 16'(hi_out), 16'hFF);
    chk(rd_n === 1'b1 && wr_n === 1'b1, "R10", 16'({rd_n, wr_n}), 16'h3);
    rst = 0; b_dis = 0; b_hi = 8'hFF;
    @(negedge clk);
    sync_ready();
    access(1, 3'd0, 16'h9999, 8'h00, 8'h55, "R10");
    access(1, 3'd3, 16'h0101, 8'h00, 8'h66, "R10");

    for (int i = 0; i < 300; i++) begin
      int r = $urandom_range(15);
      if (r == 0) reg_write(8'h8E, 8'($urandom_range(1)));
      else if (r == 1) reg_write(8'hA0, 8'($urandom));
      idle_mode  = ($urandom_range(9) == 0);
      pdown_mode = ($urandom_range(19) == 0);
      emu_mode   = ($urandom_range(19) == 0);
      ext_exec   = ($urandom_range(9) == 0);
      access($urandom_range(3) != 0, 3'($urandom_range(5)), 16'($urandom),
             8'($urandom), 8'($urandom), b_dis ? "R8" : "R1");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule